// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block drives one DMA channel from a linked list of 32-byte descriptors held in host memory. A start pulse hands it the address of the first descriptor. The walker then fetches that descriptor one 32-bit word at a time over a request/response read port. It issues a single transfer command to a downstream data mover, carrying the host address, the byte count, the direction and the local word. It waits for the mover to report completion and then moves on to the next descriptor.

Each descriptor has eight words. In order they are: host address low, host address high, local word, reserved, byte count, reserved, next-descriptor address low and next-descriptor address high. The low bits of the next-low word carry the control flags for the descriptor. A chain may end on a flagged descriptor, or it may point back to an earlier descriptor and run until software aborts it. The walker keeps a running total of the bytes moved, reports a done level, and raises an interrupt pulse on flagged descriptors.

Top module: `sg_chain_walker`

## Requirements
- R1: While in reset and after it, the walker is idle. busy_o=0, done_o=1, irq_o=0, total_o=0, and no read or transfer request is raised.
- R2: A start pulse while idle loads the descriptor address from start_addr_i with bits [4:0] forced to zero. The walker reads the eight words at that address plus 0, 4, ... 28, in ascending order. It issues each read only after the previous response has arrived.
- R3: For each descriptor with a nonzero byte count (word 4), the walker raises exactly one transfer request after all eight words are in. The request carries host address {word1, word0}, length word4 and local word2. Bit 3 of word 6 sets xfer_to_host_o (1 = write toward host). The walker issues nothing further until xfer_done_i.
- R4: The next descriptor address is {word7, word6 with bits [4:0] cleared}.
- R5: Bit 1 of word 6 marks end of chain. When that descriptor completes, the walker returns to idle with done_o=1. done_o is 0 from start until then.
- R6: Bit 2 of word 6 requests an interrupt. irq_o pulses high for exactly one cycle, the cycle after that descriptor completes.
- R7: A descriptor whose byte count is zero completes without any transfer request. Its end-of-chain and interrupt flags still take effect.
- R8: total_o clears on start and grows by the byte count of each completed transfer.
- R9: After abort_i, no new read or transfer request is issued. Any outstanding read response or transfer completion is awaited first. The walker then goes idle with done_o=1.
- R10: A start pulse while busy has no effect on the walk in progress.
- R11: A chain whose last next pointer leads back into the chain, with no end-of-chain flag, keeps running past one full lap until aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| start_addr_i | input | 64 | Address of the first descriptor |
| abort_i | input | 1 | Abort request |
| rd_req_o | output | 1 | Word read request, one cycle |
| rd_addr_o | output | 64 | Byte address of the requested word |
| rd_vld_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response data |
| xfer_req_o | output | 1 | Transfer command, one cycle |
| xfer_addr_o | output | 64 | Host address of the transfer |
| xfer_len_o | output | 32 | Byte count of the transfer |
| xfer_local_o | output | 32 | Local word of the descriptor |
| xfer_to_host_o | output | 1 | 1 = write toward host, 0 = read from host |
| xfer_done_i | input | 1 | Transfer completion pulse |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walker stopped (end of chain, abort or never started) |
| irq_o | output | 1 | Interrupt pulse |
| total_o | output | 32 | Bytes moved since start |

## Verification
The assertions assume that the read port returns exactly one response per request, at least one cycle after that request. They also assume that xfer_done_i arrives only while a transfer command is outstanding, and never unprompted. The bench's memory and mover models obey these rules: each answers only a request it has recorded, after a random latency of one to three or one to four cycles. The bench also keeps descriptor addresses and byte counts multiples of four, and keeps next-high words at zero, so the memory model can decode the low address bits only.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int WORD_W      = 32;
    localparam int HOST_W      = 2 * WORD_W;
    localparam int DESC_WORDS  = 8;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int ALIGN_BITS  = $clog2(DESC_WORDS * WORD_BYTES);
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int BYTE_SH     = $clog2(WORD_BYTES);

    // word slots inside a descriptor
    localparam int SLOT_HOST_LO = 0;
    localparam int SLOT_HOST_HI = 1;
    localparam int SLOT_LOCAL   = 2;
    localparam int SLOT_SPARE_A = 3;
    localparam int SLOT_COUNT   = 4;
    localparam int SLOT_SPARE_B = 5;
    localparam int SLOT_LINK_LO = 6;
    localparam int SLOT_LINK_HI = 7;

    // flag positions in the link-low word
    localparam int BIT_LAST   = 1;
    localparam int BIT_NOTIFY = 2;
    localparam int BIT_TOHOST = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RWAIT,
        ST_XREQ,
        ST_XWAIT
    } walk_state_e;

    typedef struct packed {
        logic last;
        logic notify;
        logic to_host;
    } link_flags_t;

    typedef struct packed {
        logic [HOST_W-1:0] host_addr;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] local_word;
        logic [WORD_W-1:0] link_lo;
        logic [WORD_W-1:0] link_hi;
    } desc_view_t;

    function automatic link_flags_t flags_of(input logic [WORD_W-1:0] link_lo);
        link_flags_t f;
        f.last    = link_lo[BIT_LAST];
        f.notify  = link_lo[BIT_NOTIFY];
        f.to_host = link_lo[BIT_TOHOST];
        return f;
    endfunction

    function automatic logic [HOST_W-1:0] align_desc(input logic [HOST_W-1:0] a);
        return {a[HOST_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/sgw_desc_regs.sv
module sgw_desc_regs
    import sgw_pkg::*;
#(
    parameter int NWORDS = DESC_WORDS,
    parameter int DW     = WORD_W,
    parameter int IW     = IDX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_i,
    input  logic [IW-1:0]             ld_idx_i,
    input  logic [DW-1:0]             ld_data_i,
    output logic [NWORDS-1:0][DW-1:0] words_o
);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_o[w] <= '0;
            end else if (ld_i && (ld_idx_i == IW'(w))) begin
                words_o[w] <= ld_data_i;
            end
        end
    end

endmodule

// File: rtl/sgw_tally.sv
module sgw_tally #(
    parameter int TW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          add_i,
    input  logic [AW-1:0] amt_i,
    output logic [TW-1:0] total_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            total_o <= '0;
        end else if (add_i) begin
            total_o <= total_o + TW'(amt_i);
        end
    end

endmodule

// File: rtl/sgw_fsm.sv
module sgw_fsm
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [HOST_W-1:0] start_addr_i,
    input  logic              abort_i,
    input  logic              rd_vld_i,
    input  logic              xfer_done_i,
    input  desc_view_t        desc_i,
    output logic              rd_req_o,
    output logic [HOST_W-1:0] rd_addr_o,
    output logic              ld_o,
    output logic [IDX_W-1:0]  ld_idx_o,
    output logic              xfer_req_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              irq_o,
    output logic              tally_clr_o,
    output logic              tally_add_o
);

    walk_state_e       state_q;
    logic [HOST_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic              abort_q;
    logic              done_q;
    logic              irq_q;

    logic              abort_now;
    logic              last_word;
    logic              zero_len;
    logic              cmpl;
    logic              stop;
    link_flags_t       flags;
    logic [HOST_W-1:0] next_base;
    logic              unused_link_bits;

    assign abort_now = abort_q | abort_i;
    assign last_word = (idx_q == IDX_W'(DESC_WORDS - 1));
    assign zero_len  = (desc_i.count == '0);
    assign flags     = flags_of(desc_i.link_lo);
    assign next_base = align_desc({desc_i.link_hi, desc_i.link_lo});
    assign unused_link_bits = desc_i.link_lo[0] ^ desc_i.link_lo[4];

    // a descriptor finishes normally
    assign cmpl = ((state_q == ST_XREQ) && !abort_now && zero_len) ||
                  ((state_q == ST_XWAIT) && xfer_done_i && !abort_now);

    // walker returns to idle this cycle
    always_comb begin
        stop = 1'b0;
        unique case (state_q)
            ST_IDLE:  stop = 1'b0;
            ST_FETCH: stop = abort_now;
            ST_RWAIT: stop = rd_vld_i && abort_now;
            ST_XREQ:  stop = abort_now || (cmpl && flags.last);
            ST_XWAIT: stop = xfer_done_i && (abort_now || flags.last);
            default:  stop = 1'b1;
        endcase
    end

    assign rd_req_o    = (state_q == ST_FETCH) && !abort_now;
    assign rd_addr_o   = base_q + HOST_W'({idx_q, {BYTE_SH{1'b0}}});
    assign ld_o        = (state_q == ST_RWAIT) && rd_vld_i;
    assign ld_idx_o    = idx_q;
    assign xfer_req_o  = (state_q == ST_XREQ) && !abort_now && !zero_len;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign irq_o       = irq_q;
    assign tally_clr_o = (state_q == ST_IDLE) && start_i;
    assign tally_add_o = (state_q == ST_XWAIT) && xfer_done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
            abort_q <= 1'b0;
            done_q  <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= cmpl && flags.notify;
            if ((state_q != ST_IDLE) && abort_i) begin
                abort_q <= 1'b1;
            end
            if (stop) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                abort_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        abort_q <= 1'b0;
                        if (start_i) begin
                            base_q  <= align_desc(start_addr_i);
                            idx_q   <= '0;
                            done_q  <= 1'b0;
                            state_q <= ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        state_q <= ST_RWAIT;
                    end
                    ST_RWAIT: begin
                        if (rd_vld_i) begin
                            if (last_word) begin
                                state_q <= ST_XREQ;
                            end else begin
                                idx_q   <= idx_q + IDX_W'(1);
                                state_q <= ST_FETCH;
                            end
                        end
                    end
                    ST_XREQ: begin
                        if (cmpl) begin
                            base_q  <= next_base;
                            idx_q   <= '0;
                            state_q <= ST_FETCH;
                        end else begin
                            state_q <= ST_XWAIT;
                        end
                    end
                    ST_XWAIT: begin
                        if (cmpl) begin
                            base_q  <= next_base;
                            idx_q   <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int TOT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [HOST_W-1:0] start_addr_i,
    input  logic              abort_i,
    output logic              rd_req_o,
    output logic [HOST_W-1:0] rd_addr_o,
    input  logic              rd_vld_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              xfer_req_o,
    output logic [HOST_W-1:0] xfer_addr_o,
    output logic [WORD_W-1:0] xfer_len_o,
    output logic [WORD_W-1:0] xfer_local_o,
    output logic              xfer_to_host_o,
    input  logic              xfer_done_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              irq_o,
    output logic [TOT_W-1:0]  total_o
);

    logic [DESC_WORDS-1:0][WORD_W-1:0] words;
    logic              ld;
    logic [IDX_W-1:0]  ld_idx;
    logic              tally_clr;
    logic              tally_add;
    desc_view_t        desc;
    logic              unused_spare;

    assign desc.host_addr  = {words[SLOT_HOST_HI], words[SLOT_HOST_LO]};
    assign desc.count      = words[SLOT_COUNT];
    assign desc.local_word = words[SLOT_LOCAL];
    assign desc.link_lo    = words[SLOT_LINK_LO];
    assign desc.link_hi    = words[SLOT_LINK_HI];
    assign unused_spare    = ^{words[SLOT_SPARE_A], words[SLOT_SPARE_B]};

    assign xfer_addr_o    = desc.host_addr;
    assign xfer_len_o     = desc.count;
    assign xfer_local_o   = desc.local_word;
    assign xfer_to_host_o = flags_of(desc.link_lo).to_host;

    sgw_desc_regs #(
        .NWORDS (DESC_WORDS),
        .DW     (WORD_W),
        .IW     (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ld_i      (ld),
        .ld_idx_i  (ld_idx),
        .ld_data_i (rd_data_i),
        .words_o   (words)
    );

    sgw_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .abort_i      (abort_i),
        .rd_vld_i     (rd_vld_i),
        .xfer_done_i  (xfer_done_i),
        .desc_i       (desc),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .ld_o         (ld),
        .ld_idx_o     (ld_idx),
        .xfer_req_o   (xfer_req_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .irq_o        (irq_o),
        .tally_clr_o  (tally_clr),
        .tally_add_o  (tally_add)
    );

    sgw_tally #(
        .TW (TOT_W),
        .AW (WORD_W)
    ) u_tally (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (tally_clr),
        .add_i   (tally_add),
        .amt_i   (desc.count),
        .total_o (total_o)
    );

endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int AW = 64,
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_vld_i,
    input logic          xfer_req_o,
    input logic          xfer_done_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          irq_o,
    input logic [TW-1:0] total_o
);

    logic rd_out;
    logic x_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_out <= 1'b0;
            x_out  <= 1'b0;
        end else begin
            if (rd_req_o)      rd_out <= 1'b1;
            else if (rd_vld_i) rd_out <= 1'b0;
            if (xfer_req_o)         x_out <= 1'b1;
            else if (xfer_done_i)   x_out <= 1'b0;
        end
    end

    // R2: one read in flight at a time
    a_r2_single_read: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> !rd_out);

    // R2: word-aligned reads
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (rd_addr_o[1:0] == 2'b00));

    // R3: one transfer in flight, no fetch while it runs
    a_r3_single_xfer: assert property (@(posedge clk) disable iff (rst)
        xfer_req_o |-> !x_out);

    a_r3_no_fetch_in_xfer: assert property (@(posedge clk) disable iff (rst)
        x_out |-> !rd_req_o);

    // R5: done only when not walking
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R6: interrupt is a single-cycle pulse
    a_r6_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R8: total never shrinks during a walk
    a_r8_total_grows: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> (total_o >= $past(total_o)));

    // R9: leaving the walk leaves nothing outstanding
    a_r9_no_orphan: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (!rd_out && !x_out));

endmodule

bind sg_chain_walker sgw_checker #(
    .AW (sgw_pkg::HOST_W),
    .TW (TOT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_vld_i    (rd_vld_i),
    .xfer_req_o  (xfer_req_o),
    .xfer_done_i (xfer_done_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .irq_o       (irq_o),
    .total_o     (total_o)
);

// File: tb/sg_chain_walker_bench.sv
`timescale 1ns/1ps
module sg_chain_walker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [63:0] start_addr_i;
    logic        abort_i;
    logic        rd_req_o;
    logic [63:0] rd_addr_o;
    logic        rd_vld_i;
    logic [31:0] rd_data_i;
    logic        xfer_req_o;
    logic [63:0] xfer_addr_o;
    logic [31:0] xfer_len_o;
    logic [31:0] xfer_local_o;
    logic        xfer_to_host_o;
    logic        xfer_done_i;
    logic        busy_o;
    logic        done_o;
    logic        irq_o;
    logic [31:0] total_o;

    always #5 clk = ~clk;

    sg_chain_walker u_sg_chain_walker (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .abort_i(abort_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i), .xfer_req_o(xfer_req_o),
        .xfer_addr_o(xfer_addr_o), .xfer_len_o(xfer_len_o),
        .xfer_local_o(xfer_local_o), .xfer_to_host_o(xfer_to_host_o),
        .xfer_done_i(xfer_done_i), .busy_o(busy_o), .done_o(done_o),
        .irq_o(irq_o), .total_o(total_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem [0:255];
    int          exp_n;
    logic [63:0] exp_addr [0:7];
    logic [31:0] exp_len  [0:7];
    logic [31:0] exp_loc  [0:7];
    logic        exp_dir  [0:7];
    int          exp_irq;
    logic [31:0] exp_tot;
    logic [63:0] exp_first;
    bit          loop_mode;

    int          xcnt, irqcnt, rreq, rresp;
    bit          first_rd;
    bit          irq_prev, irq_double;
    int          rcnt, mcnt;
    logic [63:0] raddr_q;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // memory and mover models: sample and drive at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            rd_vld_i = 1'b0; rd_data_i = '0; xfer_done_i = 1'b0;
            rcnt = 0; mcnt = 0; irq_prev = 1'b0;
        end else begin
            rd_vld_i = 1'b0;
            xfer_done_i = 1'b0;
            if (rcnt > 0) begin
                rcnt--;
                if (rcnt == 0) begin
                    rd_vld_i  = 1'b1;
                    rd_data_i = mem[raddr_q[9:2]];
                    rresp++;
                end
            end
            if (rd_req_o) begin
                rreq++;
                chk(rd_addr_o[63:10] == '0 && rd_addr_o[1:0] == 2'b00,
                    "R2 read address range", rd_addr_o, exp_first);
                if (first_rd)
                    chk(rd_addr_o == exp_first, "R2 first read aligned",
                        rd_addr_o, exp_first);
                first_rd = 1'b0;
                raddr_q = rd_addr_o;
                rcnt = 1 + int'($urandom % 3);
            end
            if (mcnt > 0) begin
                mcnt--;
                if (mcnt == 0) xfer_done_i = 1'b1;
            end
            if (xfer_req_o) begin
                int k;
                k = loop_mode ? (xcnt % exp_n) : xcnt;
                if (k < exp_n) begin
                    chk(xfer_addr_o == exp_addr[k], "R3 host address", xfer_addr_o, exp_addr[k]);
                    chk(xfer_len_o == exp_len[k], "R3 byte count", 64'(xfer_len_o), 64'(exp_len[k]));
                    chk(xfer_local_o == exp_loc[k], "R3 local word", 64'(xfer_local_o), 64'(exp_loc[k]));
                    chk(xfer_to_host_o == exp_dir[k], "R3 direction", 64'(xfer_to_host_o), 64'(exp_dir[k]));
                end else begin
                    chk(1'b0, "R3 unexpected transfer", 64'(xcnt), 64'(exp_n));
                end
                xcnt++;
                mcnt = 1 + int'($urandom % 4);
            end
            if (irq_o) irqcnt++;
            if (irq_o && irq_prev) irq_double = 1'b1;
            irq_prev = irq_o;
        end
    end

    // lay out a chain in memory and compute what the walker must do
    task automatic build(input int n, input bit lp, input int s, input int fixed_len);
        exp_n = 0; exp_irq = 0; exp_tot = 0; loop_mode = lp;
        for (int i = 0; i < n; i++) begin
            int slot, nslot;
            logic [31:0] lo, hi, len, loc, nlo;
            bit dir, irq, eoc;
            slot  = (s + i * 7) % 32;
            nslot = (s + ((i + 1) % n) * 7) % 32;
            lo  = $urandom & 32'hFFFF_FFFC;
            hi  = $urandom;
            loc = $urandom;
            if (fixed_len >= 0)                    len = 32'(fixed_len);
            else if (($urandom % 4) == 0 && !(lp && i == 0)) len = 0;
            else                                    len = (1 + ($urandom % 64)) * 4;
            dir = 1'($urandom);
            irq = (fixed_len >= 0) ? 1'b1 : 1'($urandom);
            eoc = !lp && (i == n - 1);
            nlo = 32'(nslot * 32) | (32'(eoc) << 1) | (32'(irq) << 2) |
                  (32'(dir) << 3) | ($urandom & 32'h11);
            mem[slot*8+0] = lo;   mem[slot*8+1] = hi;
            mem[slot*8+2] = loc;  mem[slot*8+3] = $urandom;
            mem[slot*8+4] = len;  mem[slot*8+5] = $urandom;
            mem[slot*8+6] = nlo;  mem[slot*8+7] = 32'h0;
            if (len != 0) begin
                exp_addr[exp_n] = {hi, lo};
                exp_len[exp_n]  = len;
                exp_loc[exp_n]  = loc;
                exp_dir[exp_n]  = dir;
                exp_n++;
                exp_tot += len;
            end
            if (irq) exp_irq++;
            if (i == 0) exp_first = 64'(slot * 32);
        end
    endtask

    task automatic clear_counts();
        xcnt = 0; irqcnt = 0; rreq = 0; rresp = 0; first_rd = 1'b1;
    endtask

    task automatic pulse_start(input logic [63:0] a);
        start_i = 1'b1; start_addr_i = a;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic pulse_abort();
        abort_i = 1'b1;
        @(posedge clk); #1;
        abort_i = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int t;
        for (t = 0; t < 6000; t++) begin
            if (!busy_o) break;
            @(posedge clk); #1;
        end
        chk(t < 6000, tag, 64'(t), 64'd6000);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic run_chain(input bit restart);
        clear_counts();
        pulse_start(exp_first | 64'($urandom & 31));
        chk(busy_o && !done_o, "R5 done low while walking", 64'(done_o), 64'd0);
        if (restart) begin
            repeat (6) @(posedge clk);
            #1;
            pulse_start(64'h3E0);
        end
        wait_idle("R5 chain reaches end");
        chk(done_o == 1'b1, "R5 done after end of chain", 64'(done_o), 64'd1);
        chk(xcnt == exp_n, restart ? "R10 transfers after restart attempt" : "R7 transfer count",
            64'(xcnt), 64'(exp_n));
        chk(total_o == exp_tot, restart ? "R10 total unchanged by restart" : "R8 byte total",
            64'(total_o), 64'(exp_tot));
        chk(irqcnt == exp_irq, "R6 interrupt count", 64'(irqcnt), 64'(exp_irq));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_sink;
        int t;
        logic [31:0] sum;
        seed_sink = $urandom(32'd4242);
        rst = 1'b1; start_i = 1'b0; start_addr_i = '0; abort_i = 1'b0;
        irq_double = 1'b0; loop_mode = 1'b0; exp_first = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        clear_counts();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1: reset state
        chk(!busy_o && done_o && !irq_o, "R1 idle flags", {61'd0, busy_o, done_o, irq_o}, 64'b010);
        chk(total_o == 0, "R1 total cleared", 64'(total_o), 64'd0);
        chk(!rd_req_o && !xfer_req_o, "R1 no requests", 64'({rd_req_o, xfer_req_o}), 64'd0);

        // R7: lone zero-length descriptor with interrupt and end flags
        build(1, 1'b0, 5, 0);
        run_chain(1'b0);
        chk(irqcnt == 1, "R7 flags kept on skipped descriptor", 64'(irqcnt), 64'd1);

        // random linear chains (R3, R4, R5, R6, R8)
        for (int r = 0; r < 20; r++) begin
            build(1 + int'($urandom % 6), 1'b0, int'($urandom % 32), -1);
            run_chain(1'b0);
        end

        // R10: start while busy
        build(4, 1'b0, 3, -1);
        run_chain(1'b1);

        // R9: abort during descriptor fetch
        build(3, 1'b0, 11, -1);
        clear_counts();
        pulse_start(exp_first);
        for (t = 0; t < 200 && rreq < 2; t++) begin
            @(posedge clk); #1;
        end
        pulse_abort();
        wait_idle("R9 abort during fetch ends walk");
        chk(done_o == 1'b1, "R9 done after abort", 64'(done_o), 64'd1);
        chk(xcnt == 0, "R9 no transfer after abort", 64'(xcnt), 64'd0);
        chk(rreq == rresp, "R9 read response awaited", 64'(rresp), 64'(rreq));
        t = rreq;
        repeat (20) @(posedge clk);
        #1;
        chk(rreq == t, "R9 reads stop after abort", 64'(rreq), 64'(t));

        // R11 / R9: looping chain, abort during a transfer
        build(3, 1'b1, 17, -1);
        clear_counts();
        pulse_start(exp_first);
        for (t = 0; t < 20000 && xcnt < exp_n + 2; t++) begin
            @(posedge clk); #1;
        end
        chk(xcnt >= exp_n + 2, "R11 loop runs past one lap", 64'(xcnt), 64'(exp_n + 2));
        pulse_abort();
        wait_idle("R9 abort of looping chain");
        sum = 0;
        for (int k = 0; k < exp_n + 2; k++) sum += exp_len[k % exp_n];
        chk(xcnt == exp_n + 2, "R9 no transfer after abort", 64'(xcnt), 64'(exp_n + 2));
        chk(total_o == sum, "R8 total includes awaited transfer", 64'(total_o), 64'(sum));
        chk(done_o == 1'b1, "R9 done after loop abort", 64'(done_o), 64'd1);

        chk(!irq_double, "R6 interrupt single cycle", 64'(irq_double), 64'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule